// File: doc/BRIEF.md
# SPI Serial Nonvolatile-Memory Slave

This block is the slave side of a four-wire serial memory. It owns a 512-byte array and answers a host that talks SPI mode 0 over chip select, serial clock, serial in and serial out. Each chip-select assertion opens one transaction. Its first byte is a command. The command may then be followed by an address byte and data bytes, or by one status byte. Writes land in the array as each byte arrives, so the host never polls for completion. A write-enable latch must be armed before any write, and it disarms itself when a write transaction ends.

The serial pins are sampled by a fast system clock. They are assumed to be already synchronised to that clock, and the serial clock is assumed to be several system clocks per half period. A hold pin freezes a transaction part-way through. A write-protect pin vetoes every write. Serial out has a separate enable, so the pad can be tri-stated.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the write-enable flag is 0 (status reads 0x00) and so_oe is 0.
- R2: Bytes travel most significant bit first. Input bits are taken on rising serial-clock edges. Output bits change only after falling serial-clock edges, so each bit is valid at the next rising edge.
- R3: Command 0x06 sets the write-enable flag and command 0x04 clears it. The flag is visible as status bit 1, so status reads 0x02 when only the flag is set.
- R4: A memory write (command 0000A010) or status write (command 0x01) while the flag is 0 changes nothing.
- R5: A read uses command 0000A011. Both read and write commands are followed by one address byte. The 9-bit address is A (command bit 3) followed by the address byte. A read returns the byte last written to that address.
- R6: In multi-byte reads and writes the address steps by one per byte and wraps from 511 to 0.
- R7: Chip select rising at the end of a memory-write or status-write transaction clears the write-enable flag. The end of any other command leaves the flag alone.
- R8: While wp_n is 0, memory writes and status writes are blocked even with the flag set.
- R9: Status layout: bit 1 is the flag, bits 3..2 are stored block-protect bits, and all other bits read 0. A status write of 0xFF with the flag set then reads back 0x0C.
- R10: Each written byte commits on its eighth bit. A trailing partial byte is discarded when chip select rises.
- R11: While hold_n is 0, serial-clock and chip-select transitions are ignored and so_oe is 0. When hold is released, the transfer resumes where it stopped.
- R12: so_oe is 1 only while chip select is low and a status or memory read is driving data.
- R13: An unrecognised command, and any byte after a complete write-enable or write-disable command, is ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so; 0 means tri-state |

## Verification
The hardest case to reach from the ports is a hold that lands in the middle of a read byte. During it the serial clock and chip select are toggled, and the output must neither advance nor abort. The stimulus stops after four data bits, drops hold_n while the clock is low, and pulses both the serial clock and chip select. It then releases hold and finishes the byte, which must still match what was stored. A second hard case is a write burst that starts at address 0x1FE with A set, so that the auto-increment crosses address bit 8 and wraps to 0. Both neighbours of the wrap point are then read back.

// File: rtl/sfm_pkg.sv
// Shared definitions for the SPI serial memory slave: command codes and
// transaction phases. Assumes 8-bit serial groups.
package sfm_pkg;
    localparam logic [7:0] OP_SET_WE  = 8'h06;
    localparam logic [7:0] OP_CLR_WE  = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [2:0] OP_MEM_RD_LO = 3'b011;
    localparam logic [2:0] OP_MEM_WR_LO = 3'b010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDAT,
        PH_RDAT,
        PH_SRD,
        PH_SWR,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/sfm_pin_front.sv
// Pin front end: registers the serial pins on the system clock and turns
// them into single-cycle events (transaction start/end, serial clock rise
// and fall). Hold gates every event and freezes the chip-select view.
// Assumes the pins are already synchronous to clk and that the serial
// clock half period spans at least a few system clocks.
module sfm_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end,
    output logic bit_rise,
    output logic bit_fall,
    output logic si_q,
    output logic hold_ok,
    output logic wp_ok
);
    logic cs_n_q, sck_q, sck_prev, hold_n_q, wp_n_q;

    // Capture pin levels and the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
            si_q     <= 1'b0;
            hold_n_q <= 1'b1;
            wp_n_q   <= 1'b0;
        end else begin
            cs_n_q   <= cs_n;
            sck_q    <= sck;
            sck_prev <= sck_q;
            si_q     <= si;
            hold_n_q <= hold_n;
            wp_n_q   <= wp_n;
        end
    end

    // Effective chip-select state; frozen while hold is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)        cs_act <= 1'b0;
        else if (hold_n_q) cs_act <= !cs_n_q;
    end

    assign hold_ok  = hold_n_q;
    assign wp_ok    = wp_n_q;
    assign cs_start = hold_n_q && !cs_n_q && !cs_act;
    assign cs_end   = hold_n_q && cs_n_q && cs_act;
    assign bit_rise = hold_n_q && cs_act && !cs_n_q && sck_q && !sck_prev;
    assign bit_fall = hold_n_q && cs_act && !cs_n_q && !sck_q && sck_prev;
endmodule

// File: rtl/sfm_store.sv
// Byte array: one synchronous write port and a combinational read of the
// same address. No reset; contents are undefined until written.
module sfm_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit a byte on the write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/sfm_cmd_engine.sv
// Command engine: shifts serial bytes, decodes the command byte, tracks the
// address, write-enable flag and block-protect bits, strobes array writes and
// shifts read data out on falling edges. Assumes one event per clock from
// the pin front end and ADDR_W-1 <= DATA_W.
module sfm_cmd_engine
    import sfm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              si_q,
    input  logic              hold_ok,
    input  logic              wp_ok,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wel,
    output logic              so,
    output logic              so_oe
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    phase_t            ph;
    logic [DATA_W-1:0] sh, osh, status, load;
    logic [CNT_W-1:0]  bcnt;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        bp;
    logic              wr_cmd, drv;
    logic [DATA_W-1:0] sh_next;
    logic              byte_done, wr_ok, is_rd_ph, is_mem_op;

    assign sh_next   = {sh[DATA_W-2:0], si_q};
    assign byte_done = bit_rise && (bcnt == LAST_BIT);
    assign wr_ok     = wel && wp_ok;
    assign is_rd_ph  = (ph == PH_RDAT) || (ph == PH_SRD);
    assign is_mem_op = (sh_next[7:4] == 4'b0000) &&
                       ((sh_next[2:0] == OP_MEM_RD_LO) || (sh_next[2:0] == OP_MEM_WR_LO));
    assign status    = DATA_W'({bp, wel, 1'b0});
    assign load      = (ph == PH_SRD) ? status : rd_data;

    assign mem_we    = byte_done && (ph == PH_WDAT) && wr_ok;
    assign mem_addr  = addr;
    assign mem_wdata = sh_next;
    assign so_oe     = drv && is_rd_ph && cs_act && hold_ok;

    // Bit counter and input shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
            sh   <= '0;
        end else if (cs_start) begin
            bcnt <= '0;
        end else if (bit_rise) begin
            bcnt <= bcnt + 1'b1;
            sh   <= sh_next;
        end
    end

    // Transaction phase sequencing and command decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
        end else if (cs_end) begin
            ph <= PH_IDLE;
        end else if (cs_start) begin
            ph <= PH_CMD;
        end else if (byte_done) begin
            case (ph)
                PH_CMD: begin
                    if (is_mem_op)                 ph <= PH_ADDR;
                    else if (sh_next == OP_STAT_RD) ph <= PH_SRD;
                    else if (sh_next == OP_STAT_WR) ph <= PH_SWR;
                    else                            ph <= PH_SKIP;
                end
                PH_ADDR: ph <= wr_cmd ? PH_WDAT : PH_RDAT;
                PH_SWR:  ph <= PH_SKIP;
                default: ph <= ph;
            endcase
        end
    end

    // Remember whether this transaction carries a write command.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start)
            wr_cmd <= 1'b0;
        else if (byte_done && ph == PH_CMD)
            wr_cmd <= (sh_next == OP_STAT_WR) ||
                      (is_mem_op && sh_next[2:0] == OP_MEM_WR_LO);
    end

    // Address: top bit from command, low bits from address byte, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (byte_done) begin
            if (ph == PH_CMD && is_mem_op)
                addr[ADDR_W-1] <= sh_next[3];
            else if (ph == PH_ADDR)
                addr[ADDR_W-2:0] <= sh_next[ADDR_W-2:0];
            else if (ph == PH_WDAT || ph == PH_RDAT)
                addr <= addr + 1'b1;
        end
    end

    // Write-enable flag: set/clear commands, cleared when a write ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (cs_end && wr_cmd) begin
            wel <= 1'b0;
        end else if (byte_done && ph == PH_CMD) begin
            if (sh_next == OP_SET_WE)      wel <= 1'b1;
            else if (sh_next == OP_CLR_WE) wel <= 1'b0;
        end
    end

    // Block-protect bits, written by an enabled status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bp <= 2'b00;
        else if (byte_done && ph == PH_SWR && wr_ok)
            bp <= sh_next[3:2];
    end

    // Output shifter: a new byte loads on the first fall of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv <= 1'b0;
            so  <= 1'b0;
            osh <= '0;
        end else if (cs_start) begin
            drv <= 1'b0;
            so  <= 1'b0;
        end else if (bit_fall && is_rd_ph) begin
            drv <= 1'b1;
            if (bcnt == '0) begin
                so  <= load[DATA_W-1];
                osh <= {load[DATA_W-2:0], 1'b0};
            end else begin
                so  <= osh[DATA_W-1];
                osh <= {osh[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_fram_slave.sv
// Top of the SPI serial memory slave: pin front end, command engine and
// byte array. Assumes mode 0 and pins synchronous to clk.
module spi_fram_slave #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    logic              cs_act, cs_start, cs_end, bit_rise, bit_fall;
    logic              si_q, hold_ok, wp_ok, mem_we, wel_flag;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    sfm_pin_front i_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .cs_act(cs_act), .cs_start(cs_start),
        .cs_end(cs_end), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .si_q(si_q), .hold_ok(hold_ok), .wp_ok(wp_ok)
    );

    sfm_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_start(cs_start),
        .cs_end(cs_end), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .si_q(si_q), .hold_ok(hold_ok), .wp_ok(wp_ok), .rd_data(mem_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wel(wel_flag), .so(so), .so_oe(so_oe)
    );

    sfm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(mem_rdata)
    );
endmodule

// File: rtl/sfm_slave_chk.sv
// Property checker for spi_fram_slave, attached by bind below.
module sfm_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic wp_n,
    input logic hold_n,
    input logic so,
    input logic so_oe,
    input logic cs_act,
    input logic bit_fall,
    input logic mem_we,
    input logic wel
);
    // R12: output only driven inside an active transaction.
    a_r12_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> cs_act);

    // R11: output released while hold was low at the pin.
    a_r11_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> $past(hold_n));

    // R8: no array write unless write protect was high.
    a_r8_wp_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wp_n));

    // R4: no array write without the write-enable flag.
    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    // R2: driven output changes only after a falling serial-clock event.
    a_r2_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(bit_fall)) |-> $stable(so));
endmodule

bind spi_fram_slave sfm_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .hold_n(hold_n), .so(so),
    .so_oe(so_oe), .cs_act(cs_act), .bit_fall(bit_fall), .mem_we(mem_we),
    .wel(wel_flag)
);

// File: tb/test_spi_fram_slave.sv
// Directed bench for spi_fram_slave: one task per scenario.
module test_spi_fram_slave;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;
    int   checks = 0, errors = 0;
    logic oe_seen;

    always #2.5 clk = ~clk;

    spi_fram_slave i_spi_fram_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        si = b;
        wait_clk(HALF);
        r = so;
        oe_seen = oe_seen | so_oe;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        oe_seen = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic rd_mem(input logic [8:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel(); xfer({4'b0, a[8], 3'b011}, d); xfer(a[7:0], d); xfer(8'h00, v); desel();
    endtask

    task automatic wr_mem(input logic [8:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer({4'b0, a[8], 3'b010}, d); xfer(a[7:0], d); xfer(v, d); desel();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 so_oe after reset", {7'b0, so_oe}, 8'h00);
        rd_status(s);
        chk("R1 status after reset", s, 8'h00);
    endtask

    task automatic t_wel();
        logic [7:0] s;
        cmd1(8'h06); rd_status(s);
        chk("R3 status after set-enable", s, 8'h02);
        cmd1(8'h04); rd_status(s);
        chk("R3 status after clear-enable", s, 8'h00);
    endtask

    task automatic t_enable_rule();
        logic [7:0] v, s;
        cmd1(8'h06); wr_mem(9'h005, 8'hC3);
        rd_mem(9'h005, v);
        chk("R5 read back 0x005", v, 8'hC3);
        rd_status(s);
        chk("R7 flag cleared after write", s, 8'h00);
        wr_mem(9'h005, 8'h3C);
        rd_mem(9'h005, v);
        chk("R4 write without flag ignored", v, 8'hC3);
    endtask

    task automatic t_protect();
        logic [7:0] v, s;
        cmd1(8'h06); wp_n = 1'b0; wr_mem(9'h005, 8'h96); wp_n = 1'b1;
        rd_mem(9'h005, v);
        chk("R8 memory write blocked by wp_n", v, 8'hC3);
        cmd1(8'h06); wp_n = 1'b0;
        sel(); xfer(8'h01, v); xfer(8'hFF, v); desel();
        wp_n = 1'b1;
        rd_status(s);
        chk("R8 status write blocked by wp_n", s, 8'h00);
    endtask

    task automatic t_burst();
        logic [7:0] d, v0, v1, v2;
        cmd1(8'h06); wr_mem(9'h0FE, 8'h44);
        cmd1(8'h06);
        sel(); xfer(8'h0A, d); xfer(8'hFE, d);
        xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d);
        chk("R12 so_oe idle during write", {7'b0, oe_seen}, 8'h00);
        desel();
        chk("R12 so_oe idle with cs high", {7'b0, so_oe}, 8'h00);
        sel(); xfer(8'h0B, d); xfer(8'hFE, d);
        xfer(8'h00, v0); xfer(8'h00, v1); xfer(8'h00, v2); desel();
        chk("R6 burst byte 0x1FE", v0, 8'h11);
        chk("R6 burst byte 0x1FF", v1, 8'h22);
        chk("R6 burst wrapped to 0x000", v2, 8'h33);
        rd_mem(9'h000, v0);
        chk("R5 single read 0x000", v0, 8'h33);
        rd_mem(9'h0FE, v0);
        chk("R5 address bit 8 selects half", v0, 8'h44);
        rd_mem(9'h1FF, v0);
        chk("R5 single read 0x1FF", v0, 8'h22);
    endtask

    task automatic t_status_write();
        logic [7:0] d, s;
        cmd1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
        rd_status(s);
        chk("R9 status after writing 0xFF", s, 8'h0C);
        chk("R7 flag cleared after status write", {7'b0, s[1]}, 8'h00);
        cmd1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
        rd_status(s);
        chk("R9 status after writing 0x00", s, 8'h00);
    endtask

    task automatic t_partial();
        logic [7:0] d, v;
        logic r;
        cmd1(8'h06); wr_mem(9'h021, 8'h5A);
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h20, d); xfer(8'h77, d);
        xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r); xbit(1'b0, r);
        desel();
        rd_mem(9'h020, v);
        chk("R10 complete byte kept", v, 8'h77);
        rd_mem(9'h021, v);
        chk("R10 partial byte discarded", v, 8'h5A);
    endtask

    task automatic t_hold();
        logic [7:0] d, v;
        logic r;
        sel(); xfer(8'h03, d); xfer(8'h20, d);
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, r); v[i] = r; end
        wait_clk(HALF);
        hold_n = 1'b0;
        wait_clk(HALF);
        chk("R11 so_oe off during hold", {7'b0, so_oe}, 8'h00);
        for (int k = 0; k < 2; k++) begin
            sck = 1'b1; si = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        cs_n = 1'b1; wait_clk(HALF); cs_n = 1'b0; wait_clk(HALF);
        chk("R11 so_oe still off in hold", {7'b0, so_oe}, 8'h00);
        hold_n = 1'b1;
        wait_clk(HALF);
        for (int i = 3; i >= 0; i--) begin xbit(1'b0, r); v[i] = r; end
        desel();
        chk("R11 byte intact across hold", v, 8'h77);
    endtask

    task automatic t_ignored();
        logic [7:0] d, s;
        sel(); xfer(8'hFF, d); xfer(8'h06, d); desel();
        rd_status(s);
        chk("R13 unknown command ignored", s, 8'h00);
        sel(); xfer(8'h04, d); xfer(8'h06, d); desel();
        rd_status(s);
        chk("R13 byte after clear-enable ignored", s, 8'h00);
        sel(); xfer(8'h06, d); xfer(8'h05, d); xfer(8'h00, d);
        chk("R13 no drive after set-enable", {7'b0, oe_seen}, 8'h00);
        desel();
        rd_status(s);
        chk("R7 flag kept after non-write command", s, 8'h02);
        cmd1(8'h04);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        oe_seen = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_wel();
        t_enable_rule();
        t_protect();
        t_burst();
        t_status_write();
        t_partial();
        t_hold();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule